// File: doc/BRIEF.md
# Multiplexed-Address DRAM Page Controller

This block turns single-cycle memory requests into the strobe sequences that a dynamic memory with a shared row/column address bus needs. Each request carries a flat cell address. The controller splits that address into a row, a bank and a column. It puts the row on the shared bus and drops the common row strobe. After the row-to-column delay it puts the column on the bus and drops the column strobe of the addressed bank only. A bank acts only when it sees both strobes. Because of this, one open row covers the columns of every bank, and the page grows with the bank count.

While requests keep hitting the open row, the row strobe stays low and only column cycles run. A request for another row, or a refresh request, closes the page. The row strobe then stays high for a programmed precharge time before the next fall. Writes are always early writes: the write strobe falls one cycle before the column strobe. Reads sample the data pin a set number of cycles after the column strobe falls and return it with a one-cycle valid pulse.

An external scheduler asks for refresh with a row number. The controller runs a row-strobe-only cycle for that row and acknowledges the request. Refresh is served before any new access once the column cycle in flight has finished.

Top module: `dram_pager`

## Requirements
- R1: The request address is `{row, bank, col}`, with the row in the top ROW_W bits, the bank in the next BANK_W bits and the column in the low COL_W bits. The row is on `mem_addr` when `ras_n` falls and the column is on it when a `cas_n` line falls. Each value is already present one cycle before its strobe falls.
- R2: For the first access after a row opens, `cas_n` falls exactly T_RCD+1 cycles after `ras_n` falls.
- R3: Consecutive requests to the open row keep `ras_n` low. A sweep through addresses in increasing order gives exactly one `ras_n` fall per row.
- R4: A request to another row raises `ras_n`. Once raised, `ras_n` stays high for at least T_RP+1 cycles before it falls again.
- R5: Each access drives exactly one `cas_n` line low: the line whose index equals the bank field. It stays low for exactly T_CAS cycles, and only while `ras_n` is low.
- R6: For a write, `we_n` is low in the cycle before the `cas_n` fall and stays low until that line rises. For a read, `we_n` stays high.
- R7: For a read, `rsp_data` is the value of `mem_rdata` sampled T_RD cycles after `cas_n` falls. `rsp_valid` is high for that one cycle, and every read gets one response.
- R8: A refresh request closes any open page and holds `rfsh_ack` high for one cycle. It then drops `ras_n` for exactly T_RFL cycles with `rfsh_row` on `mem_addr` and no `cas_n` activity.
- R9: While `rfsh_req` is high, `req_ready` is low. A request that is waiting when refresh is asked for is served only after the refresh cycle.
- R10: After reset, `ras_n`, every `cas_n` line and `we_n` are high, `rsp_valid` is low and `req_ready` is high.
- R11: A read returns the last value written to the same address, with every bank holding its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+BANK_W+COL_W | Flat cell address {row, bank, col} |
| req_wdata | input | DQ_W | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_data | output | DQ_W | Read data |
| rfsh_req | input | 1 | Refresh wanted; held until acknowledged |
| rfsh_row | input | ROW_W | Row to refresh |
| rfsh_ack | output | 1 | One-cycle refresh acknowledge |
| ras_n | output | 1 | Row strobe, common to all banks, active low |
| cas_n | output | 2**BANK_W | Column strobes, one per bank, active low |
| we_n | output | 1 | Write strobe, active low |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| mem_wdata | output | DQ_W | Data to memory |
| mem_rdata | input | DQ_W | Data from memory |

## Verification
The bench runs a small configuration: 8 rows, 2 banks and 8 columns. It sweeps every address in order, then in strided orders, against a strobe-level memory model. The in-order sweep counts row strobe falls. A controller that failed to keep the page open, or that placed the bank bits above the row, would show more falls than rows, or would latch the wrong row. The strided passes move between rows and banks. A controller that decoded the column strobe wrongly, or skipped precharge, would corrupt read-back data or shorten the row strobe's high time. One refresh is asked for while a page is open. A second is asked for in the same cycle as a same-row request. A controller that let the access through first, or that pulsed a column strobe during refresh, would be caught by the order of the response and by the strobe-only count.

// File: rtl/dram_pager_pkg.sv
package dram_pager_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROW,
    ST_RCD,
    ST_COL,
    ST_CAS,
    ST_OPEN,
    ST_PRE,
    ST_RFROW,
    ST_RFLOW
  } pg_state_e;
endpackage

// File: rtl/dram_pager_timer.sv
module dram_pager_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          expired
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt     = cnt_q;
  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dram_pager_split.sv
module dram_pager_split #(
  parameter int ROW_W  = 7,
  parameter int BANK_W = 2,
  parameter int COL_W  = 7,
  localparam int AW    = ROW_W + BANK_W + COL_W
) (
  input  logic [AW-1:0]     addr,
  output logic [ROW_W-1:0]  row,
  output logic [BANK_W-1:0] bank,
  output logic [COL_W-1:0]  col
);
  // Row on top so that one open row spans every bank's columns.
  assign row  = addr[AW-1 -: ROW_W];
  assign bank = addr[COL_W +: BANK_W];
  assign col  = addr[COL_W-1:0];
endmodule

// File: rtl/dram_pager_casdec.sv
module dram_pager_casdec #(
  parameter int BANK_W = 2,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic              en,
  input  logic [BANK_W-1:0] bank,
  output logic [NBANK-1:0]  cas_n
);
  for (genvar b = 0; b < NBANK; b++) begin : g_line
    assign cas_n[b] = !(en && (bank == BANK_W'(b)));
  end
endmodule

// File: rtl/dram_pager.sv
module dram_pager
  import dram_pager_pkg::*;
#(
  parameter int ROW_W  = 7,
  parameter int COL_W  = 7,
  parameter int BANK_W = 2,
  parameter int DQ_W   = 1,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 3,
  parameter int T_RP   = 3,
  parameter int T_RD   = 2,
  parameter int T_RFL  = 4,
  localparam int AW    = ROW_W + BANK_W + COL_W,
  localparam int NBANK = 1 << BANK_W,
  localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              rsp_valid,
  output logic [DQ_W-1:0]   rsp_data,
  input  logic              rfsh_req,
  input  logic [ROW_W-1:0]  rfsh_row,
  output logic              rfsh_ack,
  output logic              ras_n,
  output logic [NBANK-1:0]  cas_n,
  output logic              we_n,
  output logic [MA_W-1:0]   mem_addr,
  output logic [DQ_W-1:0]   mem_wdata,
  input  logic [DQ_W-1:0]   mem_rdata
);
  localparam int TM1   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int TM2   = (T_RP > T_RFL) ? T_RP : T_RFL;
  localparam int TMAX  = (TM1 > TM2) ? TM1 : TM2;
  localparam int CNT_W = (TMAX < 2) ? 1 : $clog2(TMAX);

  // Reset: asynchronous assert, synchronous release
  logic rst_s0, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_s0  <= 1'b1;
      rst_q_n <= rst_s0;
    end
  end

  // Request address fields
  logic [ROW_W-1:0]  in_row;
  logic [BANK_W-1:0] in_bank;
  logic [COL_W-1:0]  in_col;

  dram_pager_split #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_split (
    .addr (req_addr),
    .row  (in_row),
    .bank (in_bank),
    .col  (in_col)
  );

  // State and captured request
  pg_state_e         st_q, st_d;
  logic              pend_q, pend_d;
  logic              cap_en, orow_en, rfrow_en;
  logic [ROW_W-1:0]  cur_row_q, orow_q, rfrow_q;
  logic [BANK_W-1:0] cur_bank_q;
  logic [COL_W-1:0]  cur_col_q;
  logic              cur_we_q;
  logic [DQ_W-1:0]   cur_wd_q;
  logic              accept;

  // Shared interval timer
  logic             tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_val, tmr_cnt;

  dram_pager_timer #(.CW(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .cnt      (tmr_cnt),
    .expired  (tmr_exp)
  );

  assign req_ready = !rfsh_req && !pend_q && ((st_q == ST_IDLE) || (st_q == ST_OPEN));
  assign accept    = req_valid && req_ready;

  // Next-state logic
  always_comb begin
    st_d     = st_q;
    pend_d   = pend_q;
    cap_en   = 1'b0;
    orow_en  = 1'b0;
    rfrow_en = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (rfsh_req) begin
          st_d     = ST_RFROW;
          rfrow_en = 1'b1;
        end else if (pend_q) begin
          st_d   = ST_ROW;
          pend_d = 1'b0;
        end else if (accept) begin
          st_d   = ST_ROW;
          cap_en = 1'b1;
        end
      end
      ST_ROW: begin
        st_d     = ST_RCD;
        orow_en  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RCD - 1);
      end
      ST_RCD: if (tmr_exp) st_d = ST_COL;
      ST_COL: begin
        st_d     = ST_CAS;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_CAS - 1);
      end
      ST_CAS: if (tmr_exp) st_d = ST_OPEN;
      ST_OPEN: begin
        if (rfsh_req) begin
          st_d     = ST_PRE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(T_RP - 1);
        end else if (accept) begin
          cap_en = 1'b1;
          if (in_row == orow_q) begin
            st_d = ST_COL;
          end else begin
            st_d     = ST_PRE;
            pend_d   = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_RP - 1);
          end
        end
      end
      ST_PRE: if (tmr_exp) st_d = ST_IDLE;
      ST_RFROW: begin
        st_d     = ST_RFLOW;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RFL - 1);
      end
      ST_RFLOW: begin
        if (tmr_exp) begin
          st_d     = ST_PRE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(T_RP - 1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Read sampling point inside the column cycle
  logic samp;
  assign samp = (st_q == ST_CAS) && !cur_we_q && (tmr_cnt == CNT_W'(T_CAS - T_RD));

  // Control registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q      <= ST_IDLE;
      pend_q    <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      st_q      <= st_d;
      pend_q    <= pend_d;
      rsp_valid <= samp;
    end
  end

  // Data registers with explicit enables
  always_ff @(posedge clk) begin
    if (cap_en) begin
      cur_row_q  <= in_row;
      cur_bank_q <= in_bank;
      cur_col_q  <= in_col;
      cur_we_q   <= req_write;
      cur_wd_q   <= req_wdata;
    end
    if (orow_en)  orow_q   <= cur_row_q;
    if (rfrow_en) rfrow_q  <= rfsh_row;
    if (samp)     rsp_data <= mem_rdata;
  end

  // Memory-side outputs decoded from registered state
  dram_pager_casdec #(.BANK_W(BANK_W)) u_casdec (
    .en    (st_q == ST_CAS),
    .bank  (cur_bank_q),
    .cas_n (cas_n)
  );

  assign ras_n = !((st_q == ST_RCD) || (st_q == ST_COL) || (st_q == ST_CAS) ||
                   (st_q == ST_OPEN) || (st_q == ST_RFLOW));
  assign we_n      = !(cur_we_q && ((st_q == ST_COL) || (st_q == ST_CAS)));
  assign mem_wdata = cur_wd_q;
  assign rfsh_ack  = (st_q == ST_RFROW);

  always_comb begin
    unique case (st_q)
      ST_ROW, ST_RCD:     mem_addr = MA_W'(cur_row_q);
      ST_RFROW, ST_RFLOW: mem_addr = MA_W'(rfrow_q);
      default:            mem_addr = MA_W'(cur_col_q);
    endcase
  end
endmodule

// File: rtl/dram_pager_chk.sv
module dram_pager_chk #(
  parameter int NBANK = 4,
  parameter int MA_W  = 7,
  parameter int T_CAS = 3,
  parameter int T_RP  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic [NBANK-1:0] cas_n,
  input logic             we_n,
  input logic [MA_W-1:0]  mem_addr,
  input logic             req_ready,
  input logic             rfsh_req,
  input logic             rfsh_ack
);
  logic [NBANK-1:0] cas_lo;
  logic             cas_act;
  logic [31:0]      hi_cnt, lo_cnt;

  assign cas_lo  = ~cas_n;
  assign cas_act = |cas_lo;

  // Window counters: cycles with row strobe high, cycles with a column strobe low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= 32'hFFFF_FFFF;
      lo_cnt <= '0;
    end else begin
      if (ras_n) hi_cnt <= (hi_cnt == 32'hFFFF_FFFF) ? hi_cnt : hi_cnt + 1;
      else       hi_cnt <= '0;
      if (cas_act) lo_cnt <= lo_cnt + 1;
      else         lo_cnt <= '0;
    end
  end

  a_r5_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    cas_act |-> !ras_n);
  a_r5_single_cas: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cas_lo));
  a_r5_cas_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_act) |-> (lo_cnt == 32'(T_CAS)));
  a_r1_row_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(mem_addr));
  a_r1_col_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_act) |-> $stable(mem_addr));
  a_r6_early_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cas_act) && !we_n) |-> $past(!we_n));
  a_r4_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= 32'(T_RP + 1)));
  a_r9_refresh_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_req |-> !req_ready);
  a_r8_ack_then_ras: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_ack |=> (!ras_n && !cas_act));
endmodule

bind dram_pager dram_pager_chk #(
  .NBANK (NBANK),
  .MA_W  (MA_W),
  .T_CAS (T_CAS),
  .T_RP  (T_RP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .mem_addr  (mem_addr),
  .req_ready (req_ready),
  .rfsh_req  (rfsh_req),
  .rfsh_ack  (rfsh_ack)
);

// File: tb/dram_pager_bench.sv
module dram_pager_bench;
  localparam int ROW_W = 3, COL_W = 3, BANK_W = 1, DQ_W = 1;
  localparam int T_RCD = 2, T_CAS = 3, T_RP = 2, T_RD = 2, T_RFL = 3;
  localparam int AW = ROW_W + BANK_W + COL_W;
  localparam int NB = 1 << BANK_W;
  localparam int MA_W = 3;
  localparam int NCELL = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, rsp_valid;
  logic rfsh_req, rfsh_ack, ras_n, we_n;
  logic [AW-1:0] req_addr;
  logic [DQ_W-1:0] req_wdata, rsp_data, mem_wdata, mem_rdata;
  logic [ROW_W-1:0] rfsh_row;
  logic [NB-1:0] cas_n;
  logic [MA_W-1:0] mem_addr;

  dram_pager #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .DQ_W(DQ_W),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_RD(T_RD), .T_RFL(T_RFL)) u_dram_pager (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rfsh_req(rfsh_req),
    .rfsh_row(rfsh_row), .rfsh_ack(rfsh_ack), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Strobe-level memory model, indexed {row, bank, col}
  bit mem [NCELL];
  bit ref_mem [NCELL];
  int row_lat = 0, col_lat = 0, bank_lat = 0;
  assign mem_rdata = mem[(row_lat << (BANK_W + COL_W)) | (bank_lat << COL_W) | col_lat];

  int exp_q [0:1023];
  int wr_ptr = 0, rd_ptr = 0;
  int exp_addr = 0;
  int cyc = 0, ras_fall_cyc = 0, cas_fall_cyc = 0, ras_hi_len = 1000;
  int ras_falls = 0, rf_count = 0, rf_row_last = -1, ack_count = 0, rsp_rf_snap = 0;
  bit prev_ras = 1'b1, prev_cas = 1'b0, prev_we_n = 1'b1, cas_in_ras = 1'b0, mon_on = 1'b0;

  always @(negedge clk) begin
    logic cas_act;
    int idx;
    cyc++;
    cas_act = ~&cas_n;
    if (mon_on) begin
      if (!ras_n && prev_ras) begin
        ras_falls++;
        chk(ras_hi_len >= T_RP + 1, "R4 precharge high time", ras_hi_len, T_RP + 1);
        row_lat = int'(mem_addr);
        ras_fall_cyc = cyc;
        cas_in_ras = 1'b0;
      end
      if (cas_act && !prev_cas) begin
        chk(!ras_n, "R5 cas while ras low", ras_n, 0);
        chk($countones(~cas_n) == 1, "R5 single cas line", $countones(~cas_n), 1);
        idx = 0;
        for (int b = 0; b < NB; b++) if (!cas_n[b]) idx = b;
        bank_lat = idx;
        col_lat = int'(mem_addr);
        chk(bank_lat == ((exp_addr >> COL_W) & (NB - 1)), "R5 cas line = bank", bank_lat,
            (exp_addr >> COL_W) & (NB - 1));
        chk(col_lat == (exp_addr & ((1 << COL_W) - 1)), "R1 column on bus", col_lat,
            exp_addr & ((1 << COL_W) - 1));
        chk(row_lat == (exp_addr >> (BANK_W + COL_W)), "R1 row latched", row_lat,
            exp_addr >> (BANK_W + COL_W));
        if (!cas_in_ras)
          chk(cyc - ras_fall_cyc == T_RCD + 1, "R2 ras-to-cas delay", cyc - ras_fall_cyc, T_RCD + 1);
        cas_in_ras = 1'b1;
        cas_fall_cyc = cyc;
        if (!we_n) begin
          chk(!prev_we_n, "R6 we before cas", prev_we_n, 0);
          mem[(row_lat << (BANK_W + COL_W)) | (bank_lat << COL_W) | col_lat] = mem_wdata[0];
        end
      end
      if (!cas_act && prev_cas)
        chk(cyc - cas_fall_cyc == T_CAS, "R5 cas width", cyc - cas_fall_cyc, T_CAS);
      if (cas_act && !we_n)
        chk(!prev_we_n, "R6 we held through cas", prev_we_n, 0);
      if (ras_n && !prev_ras && !cas_in_ras) begin
        rf_count++;
        rf_row_last = row_lat;
        chk(cyc - ras_fall_cyc == T_RFL, "R8 refresh low time", cyc - ras_fall_cyc, T_RFL);
      end
      if (rsp_valid) begin
        chk(cyc - cas_fall_cyc == T_RD, "R7 read sample delay", cyc - cas_fall_cyc, T_RD);
        chk(rsp_data[0] == exp_q[rd_ptr][0], "R11 read data", int'(rsp_data), exp_q[rd_ptr] & 1);
        rd_ptr++;
        rsp_rf_snap = rf_count;
      end
      if (rfsh_ack) ack_count++;
    end
    ras_hi_len = ras_n ? (prev_ras ? ras_hi_len + 1 : 1) : 0;
    prev_ras = ras_n;
    prev_cas = cas_act;
    prev_we_n = we_n;
  end

  task automatic issue(input bit wr, input int a, input bit d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    exp_addr = a;
    if (wr) ref_mem[a] = d;
    else begin exp_q[wr_ptr] = int'(ref_mem[a]); wr_ptr++; end
    #1 req_valid = 1'b0;
  endtask

  task automatic do_rfsh(input int r);
    @(negedge clk);
    rfsh_req = 1'b1; rfsh_row = ROW_W'(r);
    @(negedge clk);
    while (!rfsh_ack) @(negedge clk);
    rfsh_req = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && rd_ptr != wr_ptr; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(rd_ptr == wr_ptr, "R7 every read answered", rd_ptr, wr_ptr);
  endtask

  function automatic bit wd(input int a);
    return bit'(((a * 37 + 11) >> 3) & 1);
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", rd_ptr, wr_ptr);
    finish_run();
  end

  initial begin
    int f0, rf0, a0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rfsh_req = 1'b0; rfsh_row = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ras_n == 1'b1, "R10 reset ras_n", ras_n, 1);
    chk(cas_n == '1, "R10 reset cas_n", int'(cas_n), (1 << NB) - 1);
    chk(we_n == 1'b1, "R10 reset we_n", we_n, 1);
    chk(rsp_valid == 1'b0, "R10 reset rsp_valid", rsp_valid, 0);
    chk(req_ready == 1'b1, "R10 reset req_ready", req_ready, 1);
    mon_on = 1'b1;

    // R3: in-order write sweep, one row strobe fall per row
    f0 = ras_falls;
    for (int a = 0; a < NCELL; a++) issue(1'b1, a, wd(a));
    chk(ras_falls - f0 == (1 << ROW_W), "R3 falls in write sweep", ras_falls - f0, 1 << ROW_W);

    // R3/R11: in-order read sweep
    f0 = ras_falls;
    for (int a = 0; a < NCELL; a++) issue(1'b0, a, 1'b0);
    drain();
    chk(ras_falls - f0 == (1 << ROW_W), "R3 falls in read sweep", ras_falls - f0, 1 << ROW_W);

    // R4/R11: strided rewrite and read crossing rows and banks
    for (int i = 0; i < NCELL; i++) issue(1'b1, (i * 37) % NCELL, ~wd((i * 37) % NCELL));
    for (int i = 0; i < NCELL; i++) issue(1'b0, (i * 53) % NCELL, 1'b0);
    drain();

    // R8: refresh with a page open
    rf0 = rf_count; a0 = ack_count;
    do_rfsh(5);
    repeat (12) @(negedge clk);
    chk(rf_count == rf0 + 1, "R8 strobe-only cycle count", rf_count, rf0 + 1);
    chk(rf_row_last == 5, "R8 refresh row", rf_row_last, 5);
    chk(ack_count == a0 + 1, "R8 single ack", ack_count, a0 + 1);

    // R9: refresh and same-row request arrive together
    issue(1'b0, (2 << (BANK_W + COL_W)) | 5, 1'b0);
    drain();
    rf0 = rf_count;
    fork
      do_rfsh(6);
      begin
        @(negedge clk); #2;
        chk(req_ready == 1'b0, "R9 ready low under refresh", req_ready, 0);
      end
      issue(1'b0, (2 << (BANK_W + COL_W)) | 1, 1'b0);
    join
    drain();
    chk(rsp_rf_snap == rf0 + 1, "R9 refresh before access", rsp_rf_snap, rf0 + 1);
    chk(rf_row_last == 6, "R8 second refresh row", rf_row_last, 6);

    finish_run();
  end
endmodule